// File: doc/BRIEF.md
# Interrupt-Masked Interval Monitor

This block measures how long a processor keeps its two interrupt mask bits set: the ordinary mask (I) and the non-maskable-request mask (X). The processor presents both bits together with a free-running cycle count. It also raises a step strobe at each instruction boundary. The monitor samples the bits only on that strobe. For each bit it keeps the shortest, the longest and the most recent completed interval.

Each mask bit has its own tracker. A tracker opens an interval on the first step at which its bit is found set, and it closes the interval on the first step at which the bit is found clear. A report request makes each tracker output the running length of any interval that is still open. That running length also raises the stored longest interval when it is the larger value. A report strobe follows one cycle after the request. All lengths are taken modulo the counter width, so an interval that spans a wrap of the counter still measures correctly.

Top module: `mask_interval_monitor`

## Requirements
- R1: After reset every statistic output reads 0, both open flags read 0, every current-interval output reads 0, and `report_valid_o` is 0.
- R2: On a clock edge where `step_i` is 1, the mask bit is 1 and no interval is open, the tracker records `cycle_i` as the start and sets its open flag. A later step with the bit still 1 leaves the recorded start unchanged.
- R3: On a clock edge where `step_i` is 1, the mask bit is 0 and an interval is open, the tracker clears the open flag and loads the last output with (`cycle_i` − start) modulo 2^48.
- R4: A closed interval lowers the stored minimum when it is shorter and raises the maximum when it is longer. The maximum never decreases outside reset.
- R5: Until a first interval has closed, the minimum output shows the maximum output. After that it shows the true minimum, which is never above the maximum.
- R6: A request on `report_req_i` while an interval is open loads the current output with (`cycle_i` − start) modulo 2^48. The maximum is raised to that value if it is larger. In every case `report_valid_o` is 1 exactly one cycle after each request.
- R7: A request on `report_req_i` while no interval is open loads the current output with 0 and leaves the maximum unchanged.
- R8: When `step_i` is 0, mask bit changes have no effect on the open flag, the start or any statistic.
- R9: The I tracker and the X tracker are separate. Activity on one mask bit never alters the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_i | input | 48 | Free-running cycle count |
| step_i | input | 1 | Instruction-boundary strobe; mask bits are sampled only here |
| imask_i | input | 1 | Ordinary interrupt mask bit |
| xmask_i | input | 1 | Non-maskable-request mask bit |
| report_req_i | input | 1 | Report request |
| i_min_o | output | 48 | I shortest interval (shows max until one interval closes) |
| i_max_o | output | 48 | I longest interval |
| i_last_o | output | 48 | I most recent closed interval |
| i_cur_o | output | 48 | I running length captured at the last report |
| i_open_o | output | 1 | I interval open |
| x_min_o | output | 48 | X shortest interval (shows max until one interval closes) |
| x_max_o | output | 48 | X longest interval |
| x_last_o | output | 48 | X most recent closed interval |
| x_cur_o | output | 48 | X running length captured at the last report |
| x_open_o | output | 1 | X interval open |
| report_valid_o | output | 1 | Pulses one cycle after each report request |

## Verification
The bench targets five corner cases, each of which shows up as a wrong output value:

- **Interval crossing a counter wrap.** A design that does not subtract modulo the width reports a huge or negative length.
- **Mask bit held over several steps.** A design that reloads the start on every step reports lengths that are too short.
- **Report before any interval closes.** A design that exposes the raw minimum shows all-ones instead of the folded maximum.
- **Bit toggles between steps.** A design that samples every clock opens or closes intervals it should ignore.
- **Activity on one bit only.** A design that shares state between trackers corrupts the other channel.

// File: rtl/mask_mon_pkg.sv
package mask_mon_pkg;

    localparam int CYC_W  = 48;
    localparam int NUM_CH = 2;
    localparam int CH_I   = 0;
    localparam int CH_X   = 1;

    typedef logic [CYC_W-1:0] cyc_t;

    localparam cyc_t MIN_UNSET = '1;

    typedef enum logic {
        SPAN_IDLE = 1'b0,
        SPAN_OPEN = 1'b1
    } span_state_e;

    typedef struct packed {
        cyc_t min_rd;
        cyc_t max_v;
        cyc_t last_v;
        cyc_t cur_v;
        logic open;
    } span_view_t;

    function automatic cyc_t span_len(cyc_t now, cyc_t start);
        return now - start;
    endfunction

endpackage

// File: rtl/mask_span_tracker.sv
module mask_span_tracker
    import mask_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cyc_t       cycle_i,
    input  logic       step_i,
    input  logic       bit_i,
    input  logic       report_i,
    output span_view_t view_o
);

    span_state_e state_q;
    cyc_t        start_q;
    cyc_t        min_q;
    cyc_t        max_q;
    cyc_t        last_q;
    cyc_t        cur_q;

    cyc_t run_len;
    logic opening;
    logic closing;
    logic folding;

    always_comb begin
        run_len = span_len(cycle_i, start_q);
        opening = step_i && bit_i && (state_q == SPAN_IDLE);
        closing = step_i && !bit_i && (state_q == SPAN_OPEN);
        folding = report_i && (state_q == SPAN_OPEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SPAN_IDLE;
            start_q <= '0;
            min_q   <= MIN_UNSET;
            max_q   <= '0;
            last_q  <= '0;
            cur_q   <= '0;
        end else begin
            if (opening) begin
                state_q <= SPAN_OPEN;
                start_q <= cycle_i;
            end
            if (closing) begin
                state_q <= SPAN_IDLE;
                last_q  <= run_len;
                if (run_len < min_q) begin
                    min_q <= run_len;
                end
            end
            if ((closing || folding) && (run_len > max_q)) begin
                max_q <= run_len;
            end
            if (report_i) begin
                cur_q <= folding ? run_len : '0;
            end
        end
    end

    always_comb begin
        view_o.min_rd = (min_q == MIN_UNSET) ? max_q : min_q;
        view_o.max_v  = max_q;
        view_o.last_v = last_q;
        view_o.cur_v  = cur_q;
        view_o.open   = (state_q == SPAN_OPEN);
    end

endmodule

// File: rtl/mask_report_strobe.sv
module mask_report_strobe (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic valid_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
        end else begin
            valid_o <= req_i;
        end
    end

endmodule

// File: rtl/mask_interval_monitor.sv
module mask_interval_monitor
    import mask_mon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CYC_W-1:0] cycle_i,
    input  logic             step_i,
    input  logic             imask_i,
    input  logic             xmask_i,
    input  logic             report_req_i,
    output logic [CYC_W-1:0] i_min_o,
    output logic [CYC_W-1:0] i_max_o,
    output logic [CYC_W-1:0] i_last_o,
    output logic [CYC_W-1:0] i_cur_o,
    output logic             i_open_o,
    output logic [CYC_W-1:0] x_min_o,
    output logic [CYC_W-1:0] x_max_o,
    output logic [CYC_W-1:0] x_last_o,
    output logic [CYC_W-1:0] x_cur_o,
    output logic             x_open_o,
    output logic             report_valid_o
);

    logic [NUM_CH-1:0] mask_bits;
    span_view_t        views [NUM_CH];

    assign mask_bits[CH_I] = imask_i;
    assign mask_bits[CH_X] = xmask_i;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_track
        mask_span_tracker u_track (
            .clk      (clk),
            .rst      (rst),
            .cycle_i  (cycle_i),
            .step_i   (step_i),
            .bit_i    (mask_bits[ch]),
            .report_i (report_req_i),
            .view_o   (views[ch])
        );
    end

    mask_report_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .req_i   (report_req_i),
        .valid_o (report_valid_o)
    );

    assign i_min_o  = views[CH_I].min_rd;
    assign i_max_o  = views[CH_I].max_v;
    assign i_last_o = views[CH_I].last_v;
    assign i_cur_o  = views[CH_I].cur_v;
    assign i_open_o = views[CH_I].open;
    assign x_min_o  = views[CH_X].min_rd;
    assign x_max_o  = views[CH_X].max_v;
    assign x_last_o = views[CH_X].last_v;
    assign x_cur_o  = views[CH_X].cur_v;
    assign x_open_o = views[CH_X].open;

endmodule

// File: rtl/mask_interval_monitor_chk.sv
module mask_interval_monitor_chk
    import mask_mon_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       step_i,
    input logic       report_req_i,
    input logic       report_valid_o,
    input logic [CYC_W-1:0] i_min_o,
    input logic [CYC_W-1:0] i_max_o,
    input logic [CYC_W-1:0] i_last_o,
    input logic [CYC_W-1:0] i_cur_o,
    input logic       i_open_o,
    input logic [CYC_W-1:0] x_max_o,
    input logic [CYC_W-1:0] x_last_o,
    input logic       x_open_o
);

    // R1: strobe quiet in the cycle after reset
    a_r1_strobe_reset: assert property (@(posedge clk)
        rst |=> !report_valid_o);

    // R6: strobe follows each request
    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (rst)
        report_req_i |=> report_valid_o);

    a_r6_no_spurious_strobe: assert property (@(posedge clk) disable iff (rst)
        !report_req_i |=> !report_valid_o);

    // R4: maxima never fall
    a_r4_i_max_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (i_max_o >= $past(i_max_o)));

    a_r4_x_max_monotonic: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (x_max_o >= $past(x_max_o)));

    // R5: minimum readback never above maximum
    a_r5_min_le_max: assert property (@(posedge clk) disable iff (rst)
        i_min_o <= i_max_o);

    // R7: report with no open interval gives zero
    a_r7_closed_report: assert property (@(posedge clk) disable iff (rst)
        (report_req_i && !i_open_o) |=> (i_cur_o == '0));

    // R8: no step, no change of interval state
    a_r8_no_step_stable: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> ($stable(i_open_o) && $stable(i_last_o)
                     && $stable(x_open_o) && $stable(x_last_o)));

endmodule

bind mask_interval_monitor mask_interval_monitor_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .step_i         (step_i),
    .report_req_i   (report_req_i),
    .report_valid_o (report_valid_o),
    .i_min_o        (i_min_o),
    .i_max_o        (i_max_o),
    .i_last_o       (i_last_o),
    .i_cur_o        (i_cur_o),
    .i_open_o       (i_open_o),
    .x_max_o        (x_max_o),
    .x_last_o       (x_last_o),
    .x_open_o       (x_open_o)
);

// File: tb/mask_interval_monitor_bench.sv
module mask_interval_monitor_bench;

    localparam int W = 48;
    localparam logic [W-1:0] ALL1 = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cycle_i = '0;
    logic         step_i = 1'b0;
    logic         imask_i = 1'b0;
    logic         xmask_i = 1'b0;
    logic         report_req_i = 1'b0;
    logic [W-1:0] i_min_o, i_max_o, i_last_o, i_cur_o;
    logic [W-1:0] x_min_o, x_max_o, x_last_o, x_cur_o;
    logic         i_open_o, x_open_o, report_valid_o;

    int total = 0;
    int bad   = 0;

    logic [W-1:0] m_start [2];
    logic [W-1:0] m_min   [2];
    logic [W-1:0] m_max   [2];
    logic [W-1:0] m_last  [2];
    logic [W-1:0] m_cur   [2];
    logic         m_open  [2];
    logic         m_valid;

    always #10 clk = ~clk;

    mask_interval_monitor u_mask_interval_monitor (
        .clk(clk), .rst(rst), .cycle_i(cycle_i), .step_i(step_i),
        .imask_i(imask_i), .xmask_i(xmask_i), .report_req_i(report_req_i),
        .i_min_o(i_min_o), .i_max_o(i_max_o), .i_last_o(i_last_o),
        .i_cur_o(i_cur_o), .i_open_o(i_open_o),
        .x_min_o(x_min_o), .x_max_o(x_max_o), .x_last_o(x_last_o),
        .x_cur_o(x_cur_o), .x_open_o(x_open_o),
        .report_valid_o(report_valid_o)
    );

    function automatic logic [W-1:0] exp_min(int ch);
        return (m_min[ch] == ALL1) ? m_max[ch] : m_min[ch];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_start[c] = '0; m_min[c] = ALL1; m_max[c] = '0;
            m_last[c] = '0;  m_cur[c] = '0;   m_open[c] = 1'b0;
        end
        m_valid = 1'b0;
    endtask

    task automatic model_step(int ch, logic b, logic stp, logic rep, logic [W-1:0] now);
        logic [W-1:0] run;
        logic was_open;
        run = now - m_start[ch];
        was_open = m_open[ch];
        if (rep) m_cur[ch] = was_open ? run : '0;
        if (rep && was_open && run > m_max[ch]) m_max[ch] = run;
        if (stp && b && !was_open) begin
            m_open[ch] = 1'b1; m_start[ch] = now;
        end
        if (stp && !b && was_open) begin
            m_open[ch] = 1'b0; m_last[ch] = run;
            if (run < m_min[ch]) m_min[ch] = run;
            if (run > m_max[ch]) m_max[ch] = run;
        end
    endtask

    task automatic cmp(string tag, logic [W-1:0] act, logic [W-1:0] exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        cmp(tag, i_min_o,  exp_min(0), "i_min");
        cmp(tag, i_max_o,  m_max[0],   "i_max");
        cmp(tag, i_last_o, m_last[0],  "i_last");
        cmp(tag, i_cur_o,  m_cur[0],   "i_cur");
        cmp(tag, {47'd0, i_open_o}, {47'd0, m_open[0]}, "i_open");
        cmp(tag, x_min_o,  exp_min(1), "x_min");
        cmp(tag, x_max_o,  m_max[1],   "x_max");
        cmp(tag, x_last_o, m_last[1],  "x_last");
        cmp(tag, x_cur_o,  m_cur[1],   "x_cur");
        cmp(tag, {47'd0, x_open_o}, {47'd0, m_open[1]}, "x_open");
        cmp(tag, {47'd0, report_valid_o}, {47'd0, m_valid}, "report_valid");
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic cyc(logic ib, logic xb, logic stp, logic rep, string tag);
        logic [W-1:0] now;
        imask_i = ib; xmask_i = xb; step_i = stp; report_req_i = rep;
        now = cycle_i;
        model_step(0, ib, stp, rep, now);
        model_step(1, xb, stp, rep, now);
        m_valid = rep;
        @(posedge clk);
        @(negedge clk);
        cycle_i = cycle_i + 1'b1;
        check_all(tag);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R2 R3: open, hold over steps, close
        cycle_i = 48'd100;
        cyc(1, 0, 1, 0, "R2 open");
        cyc(1, 0, 0, 0, "R2 hold");
        cyc(1, 0, 1, 0, "R2 no restart");
        cyc(1, 0, 1, 0, "R2 no restart");
        cyc(0, 0, 1, 0, "R3 close");
        // R5: first close sets min
        cyc(0, 0, 0, 0, "R5 min after close");
        // R8: toggles without step ignored
        cyc(1, 1, 0, 0, "R8 ignored");
        cyc(0, 1, 0, 0, "R8 ignored");
        cyc(1, 0, 0, 0, "R8 ignored");
        // R7: report when closed
        cyc(0, 0, 0, 1, "R7 closed report");
        // R9: X only activity, I untouched
        cyc(0, 1, 1, 0, "R9 x open");
        for (int k = 0; k < 20; k++) cyc(0, 1, 0, 0, "R9 x running");
        // R6 R5: report while X open, X min still unset reads max
        cyc(0, 1, 0, 1, "R6 fold open");
        cyc(0, 1, 0, 0, "R5 min reads max");
        cyc(0, 0, 1, 0, "R4 x close");
        // R4: shorter interval lowers I min, longer raises max
        cyc(1, 0, 1, 0, "R4 open short");
        cyc(0, 0, 1, 0, "R4 close short");
        // R3: wrap of the counter
        cycle_i = ALL1 - 48'd3;
        cyc(1, 1, 1, 0, "R3 open near wrap");
        for (int k = 0; k < 8; k++) cyc(1, 1, 0, 0, "R3 across wrap");
        cyc(0, 0, 1, 1, "R3 close after wrap");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic ib, xb, st, rp;
            ib = ($urandom % 3) != 0;
            xb = ($urandom % 4) == 0;
            st = ($urandom % 3) == 0;
            rp = ($urandom % 7) == 0;
            cyc(ib, xb, st, rp, "R2 R3 R4 R6 R9 random");
        end

        // R1: reset clears everything again
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_all("R1 re-reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule